// File: doc/BRIEF.md
# Power Supervisor Fault Sequencer

This block is the digital supervisor of a two-channel PWM power controller. It takes comparator flags that arrive asynchronously and decides when the auxiliary channel and the main channel may switch. The flags are: reference good, input undervoltage, input overvoltage, one feedback-high flag per output, bootstrap supply above the main supply, and bootstrap supply below the restart level. An enable pin and a polarity-select pin complete the set. Every flag passes through a two-flop synchronizer before it is used. A sequencer then brings up the auxiliary channel first. It brings up the main channel only once the bootstrap supply has risen above the main supply.

Two classes of fault stop switching. The first class is an input fault: loss of the reference, undervoltage or overvoltage. The second class is an output-undervoltage timeout, measured by a counter against a programmable terminal count. The two classes clear under different rules. A three-bit cause output holds the most recent fault that stopped a running supervisor.

Top module: `pfs_supervisor`

## Requirements
- R1: After reset, both run outputs are 0 and the cause output is 0 (none).
- R2: With the polarity input at 1, enable input 0 permits switching. With the polarity input at 0, enable input 1 permits switching. Dropping the permission stops both channels.
- R3: Any flag change takes effect at the third rising clock edge after it is applied (two synchronizer stages, then the state register). A loss of reference good, an undervoltage flag or an overvoltage flag drops both run outputs at that same edge.
- R4: When stopped, the supervisor starts the auxiliary channel only when three conditions hold: switching is permitted, no input fault is present, and the bootstrap-low flag is 1. This applies after reset, after a disable and after an input fault.
- R5: The main run output rises only while the auxiliary run output is already 1 and the bootstrap-above flag is 1. It never rises alone.
- R6: While a channel runs, the timer counts each cycle in which either synchronized feedback-high flag is 1. Consider a feedback flag held high with terminal count N. Both run outputs fall at the (N+3)th rising edge after the flag is applied, and the supervisor enters the timer-fault state.
- R7: The timer returns to zero in any cycle in which both feedback-high flags are 0, so separate high bursts shorter than N never trip it.
- R8: The timer-fault state is left only in a cycle with three conditions: both feedback-high flags are 0, the bootstrap-low flag is 1, and the synchronized enable or undervoltage input has changed since the previous cycle. The supervisor then waits under the R4 rule.
- R9: Cause codes: 1 reference lost, 2 input undervoltage, 3 input overvoltage, 4 timer. Simultaneous input faults are reported in that priority order. A disable leaves the cause unchanged.
- R10: A terminal count of zero disables the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ok_i | input | 1 | Reference good flag (async) |
| in_uv_i | input | 1 | Input undervoltage flag (async) |
| in_ov_i | input | 1 | Input overvoltage flag (async) |
| fb_aux_high_i | input | 1 | Auxiliary feedback above limit (async) |
| fb_main_high_i | input | 1 | Main feedback above limit (async) |
| boot_above_i | input | 1 | Bootstrap supply above main supply (async) |
| boot_low_i | input | 1 | Bootstrap supply below restart level (async) |
| enable_i | input | 1 | Enable pin (async) |
| en_pol_i | input | 1 | Enable polarity select (async) |
| tmr_limit_i | input | TW | Timer terminal count, 0 disables, quasi-static |
| run_aux_o | output | 1 | Auxiliary channel may switch |
| run_main_o | output | 1 | Main channel may switch |
| fault_cause_o | output | 3 | Most recent fault cause |

## Verification
The assertions check the rules that hold on every cycle:
- the main channel never rises without the auxiliary channel and the bootstrap-above flag;
- an input fault while running always stops both channels on the next edge;
- the auxiliary channel starts only with the restart conditions met;
- the timer counts and clears as specified;
- the timer-fault state holds until its exit condition is met.

Only the bench scenarios can show some behaviours. These are the exact three-edge and N+3-edge latencies, the cause priority, the two polarity settings, and that a toggle with feedback still high does not clear a timer fault. A cycle-level reference model compares every output on every cycle of the random phase.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_AUX  = 2'd1,
    ST_MAIN = 2'd2,
    ST_TFLT = 2'd3
  } pfs_state_e;

  typedef enum logic [2:0] {
    CZ_NONE = 3'd0,
    CZ_REF  = 3'd1,
    CZ_UV   = 3'd2,
    CZ_OV   = 3'd3,
    CZ_TMR  = 3'd4
  } pfs_cause_e;

  typedef struct packed {
    logic pol;
    logic en;
    logic boot_low;
    logic boot_gt;
    logic fb2;
    logic fb1;
    logic ov;
    logic uv;
    logic ref_ok;
  } pfs_flags_t;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  generate
    if (STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg[0] <= d;
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pfs_uv_timer.sv
module pfs_uv_timer #(
  parameter int unsigned TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          count_en,
  input  logic          fb_any,
  input  logic [TW-1:0] limit,
  output logic          trip
);
  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (count_en && fb_any) begin
      if (cnt_q != CNT_MAX)     cnt_q <= cnt_q + 1'b1;
    end else                    cnt_q <= '0;
  end

  assign trip = (limit != '0) && (cnt_q >= limit);

  // R7
  tmr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_any |=> cnt_q == '0);

  // R6
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && fb_any && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/pfs_fault_ctl.sv
module pfs_fault_ctl
  import pfs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pfs_flags_t flg,
  input  logic       trip,
  output logic       running,
  output logic       run_aux,
  output logic       run_main,
  output pfs_cause_e cause
);
  pfs_state_e st_q, st_d;
  pfs_cause_e cz_q, cz_d;
  logic       en_prev_q, uv_prev_q;
  logic       en_ok, in_fault, fb_any, toggled;

  function automatic pfs_cause_e input_cause(input pfs_flags_t f);
    if (!f.ref_ok) return CZ_REF;
    else if (f.uv) return CZ_UV;
    else           return CZ_OV;
  endfunction

  always_comb begin
    en_ok    = flg.pol ? ~flg.en : flg.en;
    in_fault = ~flg.ref_ok | flg.uv | flg.ov;
    fb_any   = flg.fb1 | flg.fb2;
    toggled  = (flg.en != en_prev_q) | (flg.uv != uv_prev_q);
  end

  always_comb begin
    st_d = st_q;
    cz_d = cz_q;
    unique case (st_q)
      ST_STOP: if (en_ok && !in_fault && flg.boot_low) st_d = ST_AUX;
      ST_AUX, ST_MAIN: begin
        if (in_fault) begin
          st_d = ST_STOP;
          cz_d = input_cause(flg);
        end else if (!en_ok) begin
          st_d = ST_STOP;
        end else if (trip) begin
          st_d = ST_TFLT;
          cz_d = CZ_TMR;
        end else if (st_q == ST_AUX && flg.boot_gt) begin
          st_d = ST_MAIN;
        end
      end
      ST_TFLT: if (!fb_any && flg.boot_low && toggled) st_d = ST_STOP;
      default: st_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_STOP;
      cz_q      <= CZ_NONE;
      en_prev_q <= 1'b0;
      uv_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      cz_q      <= cz_d;
      en_prev_q <= flg.en;
      uv_prev_q <= flg.uv;
    end
  end

  assign running  = (st_q == ST_AUX) || (st_q == ST_MAIN);
  assign run_aux  = running;
  assign run_main = (st_q == ST_MAIN);
  assign cause    = cz_q;

  // R5
  main_after_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_main) |-> ($past(run_aux) && $past(flg.boot_gt)));

  // R3
  input_fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && in_fault) |=> (!run_aux && !run_main));

  // R4
  restart_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_aux) |-> ($past(flg.boot_low) && $past(en_ok) && !$past(in_fault)));

  // R8
  tflt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TFLT && (fb_any || !flg.boot_low || !toggled)) |=> st_q == ST_TFLT);

  // R9
  tmr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !in_fault && en_ok && trip) |=> (cause == CZ_TMR && !run_aux));
endmodule

// File: rtl/pfs_supervisor.sv
module pfs_supervisor
  import pfs_pkg::*;
#(
  parameter int unsigned TW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ok_i,
  input  logic          in_uv_i,
  input  logic          in_ov_i,
  input  logic          fb_aux_high_i,
  input  logic          fb_main_high_i,
  input  logic          boot_above_i,
  input  logic          boot_low_i,
  input  logic          enable_i,
  input  logic          en_pol_i,
  input  logic [TW-1:0] tmr_limit_i,
  output logic          run_aux_o,
  output logic          run_main_o,
  output logic [2:0]    fault_cause_o
);
  localparam int unsigned FW = $bits(pfs_flags_t);

  pfs_flags_t raw_flags, syn_flags;
  logic       running, trip;
  pfs_cause_e cause;

  assign raw_flags = {en_pol_i, enable_i, boot_low_i, boot_above_i,
                      fb_main_high_i, fb_aux_high_i, in_ov_i, in_uv_i, ref_ok_i};

  pfs_sync #(.W(FW), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst_n (rst_n),
    .d   (raw_flags),
    .q   (syn_flags)
  );

  pfs_uv_timer #(.TW(TW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_en (running),
    .fb_any   (syn_flags.fb1 | syn_flags.fb2),
    .limit    (tmr_limit_i),
    .trip     (trip)
  );

  pfs_fault_ctl ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .flg      (syn_flags),
    .trip     (trip),
    .running  (running),
    .run_aux  (run_aux_o),
    .run_main (run_main_o),
    .cause    (cause)
  );

  assign fault_cause_o = cause;
endmodule

// File: tb/pfs_supervisor_tb_top.sv
module pfs_supervisor_tb_top;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refok, uv, ov, fb1, fb2, bgt, blow, en, pol;
  logic [TW-1:0] lim;
  logic run_aux, run_main;
  logic [2:0] cause;

  int n_chk = 0;
  int n_err = 0;

  // model state
  logic [8:0] m1, m2;
  int  m_st, m_cz, m_cnt;
  logic m_pen, m_puv;

  always #2 clk = ~clk;

  pfs_supervisor #(.TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_ok_i(refok), .in_uv_i(uv), .in_ov_i(ov),
    .fb_aux_high_i(fb1), .fb_main_high_i(fb2), .boot_above_i(bgt),
    .boot_low_i(blow), .enable_i(en), .en_pol_i(pol), .tmr_limit_i(lim),
    .run_aux_o(run_aux), .run_main_o(run_main), .fault_cause_o(cause)
  );

  function automatic int exp_aux(); return (m_st == 1 || m_st == 2) ? 1 : 0; endfunction
  function automatic int exp_main(); return (m_st == 2) ? 1 : 0; endfunction

  // Reference model from the requirements: bit 0 ref, 1 uv, 2 ov, 3 fb1,
  // 4 fb2, 5 boot above, 6 boot low, 7 enable, 8 polarity.
  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      m1 = '0; m2 = '0; m_st = 0; m_cz = 0; m_cnt = 0; m_pen = 0; m_puv = 0;
    end else begin
      logic [8:0] s;
      logic ok, flt, fb, tog, trp, run;
      int nst, ncz;
      s   = m2;
      ok  = s[8] ? !s[7] : s[7];
      flt = !s[0] || s[1] || s[2];
      fb  = s[3] || s[4];
      tog = (s[7] != m_pen) || (s[1] != m_puv);
      trp = (lim != 0) && (m_cnt >= int'(lim));
      run = (m_st == 1 || m_st == 2);
      nst = m_st; ncz = m_cz;
      case (m_st)
        0: if (ok && !flt && s[6]) nst = 1;
        1, 2: begin
          if (flt) begin nst = 0; ncz = !s[0] ? 1 : (s[1] ? 2 : 3); end
          else if (!ok) nst = 0;
          else if (trp) begin nst = 3; ncz = 4; end
          else if (m_st == 1 && s[5]) nst = 2;
        end
        default: if (!fb && s[6] && tog) nst = 0;
      endcase
      if (run && fb) begin if (m_cnt < 65535) m_cnt = m_cnt + 1; end
      else m_cnt = 0;
      m_st = nst; m_cz = ncz;
      m_pen = s[7]; m_puv = s[1];
      m2 = m1;
      m1 = {pol, en, blow, bgt, fb2, fb1, ov, uv, refok};
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_n) begin
        check("R4 model run_aux", int'(run_aux), exp_aux());
        check("R5 model run_main", int'(run_main), exp_main());
        check("R9 model cause", int'(cause), m_cz);
      end
    end
  endtask

  function automatic logic flip(input logic v, input int pct);
    return ($urandom_range(0, 999) < pct) ? !v : v;
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog all actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    refok = 1; uv = 0; ov = 0; fb1 = 0; fb2 = 0; bgt = 0; blow = 1; en = 0; pol = 1;
    lim = 16'd5;
    repeat (3) @(negedge clk);
    check("R1 reset run_aux", int'(run_aux), 0);
    check("R1 reset run_main", int'(run_main), 0);
    check("R1 reset cause", int'(cause), 0);
    rst_n = 1;
    step(2); check("R3 latency aux low", int'(run_aux), 0);
    step(1); check("R2 pol high en low aux", int'(run_aux), 1);
    check("R5 main waits", int'(run_main), 0);
    blow = 0; bgt = 1;
    step(2); check("R5 main before 3rd edge", int'(run_main), 0);
    step(1); check("R5 main up", int'(run_main), 1);
    ov = 1;
    step(2); check("R3 still running", int'(run_aux), 1);
    step(1); check("R3 ov aux", int'(run_aux), 0);
    check("R3 ov main", int'(run_main), 0);
    check("R9 ov cause", int'(cause), 3);
    ov = 0;
    step(6); check("R4 no restart boot high", int'(run_aux), 0);
    blow = 1; bgt = 0;
    step(3); check("R4 restart", int'(run_aux), 1);
    check("R5 main off", int'(run_main), 0);
    bgt = 1;
    step(3); check("R5 main again", int'(run_main), 1);
    pol = 0;
    step(3); check("R2 pol low en low stop", int'(run_aux), 0);
    check("R9 disable keeps cause", int'(cause), 3);
    en = 1;
    step(3); check("R2 pol low en high aux", int'(run_aux), 1);
    step(1); check("R5 main", int'(run_main), 1);
    uv = 1; refok = 0;
    step(3); check("R9 ref over uv", int'(cause), 1);
    uv = 0; refok = 1;
    step(4); check("R4 back up", int'(run_main), 1);
    fb1 = 1;
    step(7); check("R6 before trip", int'(run_aux), 1);
    step(1); check("R6 trip aux", int'(run_aux), 0);
    check("R6 trip main", int'(run_main), 0);
    check("R9 timer cause", int'(cause), 4);
    en = 0; step(4); en = 1; step(4);
    check("R8 toggle with fb high", int'(run_aux), 0);
    fb1 = 0;
    step(4); check("R8 no toggle", int'(run_aux), 0);
    en = 0; step(4); check("R8 cleared but disabled", int'(run_aux), 0);
    en = 1; step(3); check("R8 restart after clear", int'(run_aux), 1);
    step(1);
    fb2 = 1; step(4); fb2 = 0; step(2); fb2 = 1; step(4); fb2 = 0; step(4);
    check("R7 bursts no trip", int'(run_aux), 1);
    lim = 16'd0; fb1 = 1;
    step(30); check("R10 zero limit", int'(run_aux), 1);
    fb1 = 0; step(4);
    for (int c = 0; c < 6000; c++) begin
      if (c % 500 == 0) lim = 16'($urandom_range(1, 8));
      refok = refok ? flip(refok, 3) : flip(refok, 60);
      uv    = uv ? flip(uv, 80) : flip(uv, 3);
      ov    = ov ? flip(ov, 80) : flip(ov, 3);
      fb1   = fb1 ? flip(fb1, 120) : flip(fb1, 15);
      fb2   = fb2 ? flip(fb2, 120) : flip(fb2, 15);
      bgt   = flip(bgt, 60);
      blow  = flip(blow, 60);
      en    = flip(en, 20);
      pol   = flip(pol, 3);
      step(1);
    end
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule